// File: doc/BRIEF.md
# Serializer Link Mode Sequencer

This block is the control state machine of a word-parallel serializer. It runs on the word-rate clock and moves the transmitter through three phases: a lock wait after power-up or after power-down is released, a synchronization phase that sends framing-only words so that a far-end deserializer can acquire the bit clock, and normal data transmission. The lock wait is modelled as a fixed count of word clocks; there is no real PLL lock detector.

Two request inputs are combined into one sync request. The request has to be held for a minimum number of consecutive word clocks before a burst starts. Once a burst has started it always runs its full frame count. It is extended for as long as the request stays high. The block produces two outputs for the serial datapath: a frame-type select (sync frames or data frames) and an output-drive control. When the drive control is low, the line driver goes to high impedance. The enable input acts on that drive control only, and does not touch the sequencing.

Top module: `link_sync_ctrl`

## Requirements
- R1: The two request inputs act as one: a request on either input, or on both, has the same effect.
- R2: From data mode, the combined request must be sampled high on 6 consecutive clock edges before sync mode starts. `sel_sync` is 1 after the sixth such edge. A run of 5 or fewer starts nothing.
- R3: A started burst lasts at least 1024 clocks with `sel_sync` = 1. Dropping or pulsing the request during that time does not shorten the burst.
- R4: While the request stays high, sync mode continues. If the request is high for L edges, counted from the start of the triggering run, the burst lasts max(1024, L-5) clocks.
- R5: After reset is released, `drive_out` and `sel_sync` stay 0 for 2048 clock edges. The lock wait ends on edge 2049.
- R6: When the lock wait ends, the block enters sync mode (`sel_sync` = 1) if the request is high, and data mode (`sel_sync` = 0, `drive_out` = `out_en`) if it is low.
- R7: While `pd_n` is 0, `drive_out` is 0 at once, without waiting for a clock edge. The next edge returns the block to the lock wait with `sel_sync` = 0. After `pd_n` rises, the full 2049-edge wait is needed again.
- R8: `out_en` = 0 forces `drive_out` to 0 and changes nothing else. `sel_sync` and the burst length are not affected.
- R9: During reset and during the lock wait, `sel_sync` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req_a | input | 1 | Sync request, first source |
| sync_req_b | input | 1 | Sync request, second source |
| pd_n | input | 1 | Power-down when 0 |
| out_en | input | 1 | Output enable for the line driver |
| sel_sync | output | 1 | 1: send sync frames, 0: send data frames |
| drive_out | output | 1 | 1: drive the line, 0: high impedance |

## Verification
The mode is registered. A change on the request inputs that is sampled at an edge therefore shows on `sel_sync` right after that edge. A trigger appears after the sixth high edge. The end of a burst appears after the first edge at which the request is low and the frame count is complete. The bench drives inputs on the falling edge and samples on the falling edge that follows each rising edge. A burst is measured by counting the samples with `sel_sync` high, and that count is compared with max(1024, L-5). The lock wait is checked at the samples after edges 2048 and 2049. The power-down path is combinational, so it is checked 1 ns after `pd_n` falls.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        PH_LOCK = 2'd0,
        PH_SYNC = 2'd1,
        PH_DATA = 2'd2
    } lsc_phase_e;

    typedef struct packed {
        logic sync_frames;
        logic line_drive;
    } lsc_ctl_t;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lsc_lock_timer.sv
module lsc_lock_timer #(
    parameter int unsigned WAIT_EDGES = 2049
) (
    input  logic clk,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int unsigned W = lsc_pkg::cnt_bits(WAIT_EDGES);
    localparam logic [W-1:0] LAST = W'(WAIT_EDGES - 1);

    logic [W-1:0] elapsed_q;

    assign expire = run && (elapsed_q == LAST);

    always_ff @(posedge clk) begin
        if (clear) begin
            elapsed_q <= '0;
        end else if (run && !expire) begin
            elapsed_q <= elapsed_q + 1'b1;
        end else if (!run) begin
            elapsed_q <= '0;
        end
    end
endmodule

// File: rtl/lsc_hold_filter.sv
module lsc_hold_filter #(
    parameter int unsigned HOLD = 6
) (
    input  logic clk,
    input  logic clear,
    input  logic req,
    output logic fire
);
    localparam int unsigned W = lsc_pkg::cnt_bits(HOLD);

    generate
        if (HOLD <= 1) begin : g_direct
            assign fire = req;
        end else begin : g_count
            localparam logic [W-1:0] TOP  = W'(HOLD);
            localparam logic [W-1:0] NEAR = W'(HOLD - 1);
            logic [W-1:0] run_q;

            assign fire = req && (run_q >= NEAR);

            always_ff @(posedge clk) begin
                if (clear || !req) begin
                    run_q <= '0;
                end else if (run_q != TOP) begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lsc_burst_counter.sv
module lsc_burst_counter #(
    parameter int unsigned FRAMES = 1024
) (
    input  logic clk,
    input  logic restart,
    input  logic tick,
    output logic complete
);
    localparam int unsigned W = lsc_pkg::cnt_bits(FRAMES);
    localparam logic [W-1:0] TOP  = W'(FRAMES);
    localparam logic [W-1:0] NEAR = W'(FRAMES - 1);

    logic [W-1:0] sent_q;

    // the frame sent in this cycle makes the count reach FRAMES
    assign complete = (sent_q >= NEAR);

    always_ff @(posedge clk) begin
        if (restart) begin
            sent_q <= '0;
        end else if (tick && (sent_q != TOP)) begin
            sent_q <= sent_q + 1'b1;
        end
    end
endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl #(
    parameter int unsigned LOCK_EDGES   = 2049,
    parameter int unsigned REQ_HOLD     = 6,
    parameter int unsigned BURST_FRAMES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_req_a,
    input  logic sync_req_b,
    input  logic pd_n,
    input  logic out_en,
    output logic sel_sync,
    output logic drive_out
);
    import lsc_pkg::*;

    lsc_phase_e phase_q, phase_d;
    lsc_ctl_t   ctl;
    logic       req_any;
    logic       hard_clear;
    logic       lock_done;
    logic       req_fire;
    logic       burst_full;

    assign req_any    = sync_req_a | sync_req_b;
    assign hard_clear = rst | ~pd_n;

    lsc_lock_timer #(.WAIT_EDGES(LOCK_EDGES)) u_lock (
        .clk    (clk),
        .clear  (hard_clear),
        .run    (phase_q == PH_LOCK),
        .expire (lock_done)
    );

    lsc_hold_filter #(.HOLD(REQ_HOLD)) u_filt (
        .clk   (clk),
        .clear (hard_clear),
        .req   (req_any),
        .fire  (req_fire)
    );

    lsc_burst_counter #(.FRAMES(BURST_FRAMES)) u_burst (
        .clk      (clk),
        .restart  (hard_clear | (phase_q != PH_SYNC)),
        .tick     (phase_q == PH_SYNC),
        .complete (burst_full)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOCK: if (lock_done) phase_d = req_any ? PH_SYNC : PH_DATA;
            PH_SYNC: if (burst_full && !req_any) phase_d = PH_DATA;
            PH_DATA: if (req_fire) phase_d = PH_SYNC;
            default: phase_d = PH_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_clear) begin
            phase_q <= PH_LOCK;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        ctl.sync_frames = (phase_q == PH_SYNC);
        ctl.line_drive  = pd_n & out_en & (phase_q != PH_LOCK);
    end

    assign sel_sync  = ctl.sync_frames;
    assign drive_out = ctl.line_drive;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int unsigned LOCK_EDGES   = 2049,
    parameter int unsigned BURST_FRAMES = 1024
) (
    input logic clk,
    input logic rst,
    input logic sync_req_a,
    input logic sync_req_b,
    input logic pd_n,
    input logic sel_sync,
    input logic drive_out
);
    localparam int unsigned UW = lsc_pkg::cnt_bits(LOCK_EDGES);
    localparam int unsigned RW = lsc_pkg::cnt_bits(BURST_FRAMES) + 1;
    localparam logic [UW-1:0] UTOP = UW'(LOCK_EDGES);
    localparam logic [RW-1:0] RTOP = {RW{1'b1}};

    logic [UW-1:0] up_cnt;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !pd_n) up_cnt <= '0;
        else if (up_cnt != UTOP) up_cnt <= up_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !sel_sync) run_len <= '0;
        else if (run_len != RTOP) run_len <= run_len + 1'b1;
    end

    // R7
    pd_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_n |-> !drive_out);

    // R7
    pd_relock_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> !sel_sync);

    // R5
    lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cnt < UTOP) |-> (!drive_out && !sel_sync));

    // R4
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_sync && (sync_req_a || sync_req_b) && pd_n) |=> sel_sync);

    // R3
    burst_min_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sel_sync) && $past(pd_n) && !$past(rst)) |-> (run_len >= RW'(BURST_FRAMES)));
endmodule

bind link_sync_ctrl lsc_checker #(
    .LOCK_EDGES   (LOCK_EDGES),
    .BURST_FRAMES (BURST_FRAMES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_req_a (sync_req_a),
    .sync_req_b (sync_req_b),
    .pd_n       (pd_n),
    .sel_sync   (sel_sync),
    .drive_out  (drive_out)
);

// File: tb/link_sync_ctrl_test.sv
module link_sync_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_req_a = 1'b0;
    logic sync_req_b = 1'b0;
    logic pd_n = 1'b1;
    logic out_en = 1'b1;
    logic sel_sync;
    logic drive_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    link_sync_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .sync_req_a (sync_req_a),
        .sync_req_b (sync_req_b),
        .pd_n       (pd_n),
        .out_en     (out_en),
        .sel_sync   (sel_sync),
        .drive_out  (drive_out)
    );

    typedef struct packed {
        logic [15:0] hold;
        logic [1:0]  src;
        logic [15:0] exp_len;
    } vec_t;

    // request run length, source (1=a, 2=b, 3=both), expected burst clocks
    localparam vec_t VEC [8] = '{
        '{16'd5,    2'd1, 16'd0},
        '{16'd6,    2'd1, 16'd1024},
        '{16'd6,    2'd2, 16'd1024},
        '{16'd7,    2'd3, 16'd1024},
        '{16'd3,    2'd3, 16'd0},
        '{16'd1029, 2'd1, 16'd1024},
        '{16'd1030, 2'd2, 16'd1025},
        '{16'd1500, 2'd3, 16'd1495}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [1:0] src);
        sync_req_a = src[0];
        sync_req_b = src[1];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        set_req(2'd0);
        step(3);
        check("R9 reset sel_sync", int'(sel_sync), 0);
        check("R7 reset drive_out", int'(drive_out), 0);
        rst = 1'b0;
    endtask

    // raise a request for 'hold' edges and count clocks in sync mode
    task automatic measure(input int hold, input logic [1:0] src,
                           input int mute_at, input int blip_at,
                           output int len);
        len = 0;
        set_req(src);
        for (int i = 1; i <= hold + 1100; i++) begin
            step(1);
            if (sel_sync) len++;
            if (mute_at != 0 && i == mute_at + 1) begin
                check("R8 drive muted", int'(drive_out), 0);
                check("R8 mode kept", int'(sel_sync), 1);
            end
            if (i == hold) set_req(2'd0);
            if (mute_at != 0 && i == mute_at) out_en = 1'b0;
            if (mute_at != 0 && i == mute_at + 50) out_en = 1'b1;
            if (blip_at != 0 && i == blip_at) sync_req_a = 1'b1;
            if (blip_at != 0 && i == blip_at + 10) sync_req_a = 1'b0;
        end
    endtask

    function automatic string vec_tag(input vec_t v);
        if (v.hold < 16'd6) return "R2";
        if (v.hold > 16'd1029) return "R4";
        return "R1";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int len;
        do_reset();

        // R5: lock wait after reset
        step(2048);
        check("R5 drive before lock", int'(drive_out), 0);
        check("R9 sel_sync in lock wait", int'(sel_sync), 0);
        step(1);
        check("R5 drive after lock", int'(drive_out), 1);
        check("R6 data after lock", int'(sel_sync), 0);

        // table of request patterns from data mode
        foreach (VEC[k]) begin
            step(4);
            measure(int'(VEC[k].hold), VEC[k].src, 0, 0, len);
            check(vec_tag(VEC[k]), len, int'(VEC[k].exp_len));
        end

        // R3: request pulses inside a running burst
        step(4);
        measure(6, 2'd1, 0, 300, len);
        check("R3 burst with pulse", len, 1024);

        // R8: enable dropped during a burst
        step(4);
        measure(6, 2'd2, 100, 0, len);
        check("R8 burst length", len, 1024);
        check("R8 drive restored", int'(drive_out), 1);

        // R7: power-down during a burst
        step(4);
        set_req(2'd1);
        step(200);
        set_req(2'd0);
        check("R7 in burst", int'(sel_sync), 1);
        pd_n = 1'b0;
        #1;
        check("R7 immediate hiz", int'(drive_out), 0);
        step(1);
        check("R7 mode cleared", int'(sel_sync), 0);
        step(4);
        pd_n = 1'b1;
        step(2048);
        check("R7 relock wait", int'(drive_out), 0);
        step(1);
        check("R7 relocked", int'(drive_out), 1);
        check("R7 data after relock", int'(sel_sync), 0);

        // R6: request already high when lock ends
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        sync_req_b = 1'b1;
        step(2048);
        check("R9 no sync before lock", int'(sel_sync), 0);
        step(1);
        check("R6 sync after lock", int'(sel_sync), 1);
        sync_req_b = 1'b0;
        len = 1;
        for (int i = 0; i < 1100; i++) begin
            step(1);
            if (sel_sync) len++;
        end
        check("R6 burst after lock", len, 1024);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule